// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Preamble Sequencing

This block serializes 8-bit or 9-bit characters onto a single asynchronous line that idles high. A character is written into a one-entry holding register and is moved into the shift register at the next bit boundary. Each character is sent as a low start bit, the data least significant bit first, an optional ninth bit, and a high stop bit. Bit timing comes from an external baud tick that is counted a set number of times per bit, so the same core serves a 16x or a 1x tick.

Besides data, the sequencer produces three special line patterns. A preamble (an all-ones character time) goes out when the transmitter is enabled. A break (an all-zeros character time) goes out on request, followed by one high bit when the request has been released. Breaks repeat back to back while the request is held. A break that is requested before the preamble has begun takes the preamble's place. The transmit-complete flag tells software when the line has gone quiet with nothing left to send.

Top module: `sertx_core`

## Requirements
- R1: After reset the line output is 1, the buffer-empty flag is 1 and the transmit-complete flag is 1.
- R2: A data character is one 0 start bit, then the data bits least significant bit first, then one 1 stop bit; every frame starts on a bit boundary, which falls once every TICKS_PER_BIT baud ticks counted from reset, and the line is 1 in every bit time with no frame.
- R3: With the 9-bit mode input at 1, the ninth bit captured together with the byte is sent between the last data bit and the stop bit, and break and preamble last 11 bit times instead of 10.
- R4: The buffer-empty flag goes to 0 the cycle after an accepted write and returns to 1 when the byte moves into the shifter; a byte written while a frame is in flight is sent right after that frame with no idle bit between.
- R5: A rising transmitter enable sends one preamble of 10 (or 11) 1 bits before any data character that is waiting.
- R6: A rising break request that is released before the break ends sends exactly one break of 10 (or 11) 0 bits, then exactly one 1 bit.
- R7: While the break request stays at 1, breaks are sent back to back with no 1 bit between them; after release the last break is followed by one 1 bit.
- R8: A break that starts before the pending preamble has begun cancels that preamble.
- R9: The transmit-complete flag is 1 only when no frame is on the line and no preamble, break, trailing 1 bit or buffered byte is pending.
- R10: While the transmitter enable is 0, writes are ignored and no new frame starts.
- R11: Reset clears a latched break request, so no break follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Baud tick enable, one per oversample period |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Break request level |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| bit8_in | input | 1 | Ninth bit, captured with the written byte |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Transmitter fully idle |

## Verification
The hardest case to reach is a break request that arrives after the enable has risen but before the preamble has begun, since the window is less than one bit time wide and a preamble looks the same as an idle line. The bench makes its own bit grid from the ticks it drives, raises the enable, pulses the break request and writes a byte all within the same half bit, and then expects the byte's start bit right after the trailing 1 bit, where a preamble that was not cancelled would have put ten more idle bits. Held breaks are released in the middle of the third break so that the count of back-to-back breaks is exact.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    FK_IDLE = 3'd0,
    FK_DATA = 3'd1,
    FK_PRE  = 3'd2,
    FK_BRK  = 3'd3,
    FK_MARK = 3'd4
  } frame_kind_e;
endpackage

// File: rtl/sertx_bit_clock.sv
module sertx_bit_clock #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic bit_edge
);
  generate
    if (TICKS_PER_BIT == 1) begin : g_direct
      assign bit_edge = tick;
    end else begin : g_count
      localparam int PCW = $clog2(TICKS_PER_BIT);
      localparam logic [PCW-1:0] PC_LAST = PCW'(TICKS_PER_BIT - 1);
      logic [PCW-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase <= '0;
        end else if (tick) begin
          phase <= (phase == PC_LAST) ? '0 : phase + 1'b1;
        end
      end
      assign bit_edge = tick && (phase == PC_LAST);
    end
  endgenerate
endmodule

// File: rtl/sertx_hold_buf.sv
module sertx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              accept,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit8_in,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              b8
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
      b8   <= 1'b0;
    end else if (wr_stb && accept) begin
      full <= 1'b1;
      data <= wr_data;
      b8   <= bit8_in;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_arbiter.sv
module sertx_arbiter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FW = DATA_W + 3,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              nine_bit,
  input  logic              slot,
  input  logic              bit_edge,
  input  logic              frame_end,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_b8,
  output logic              load,
  output logic [FW-1:0]     load_vec,
  output logic [LW-1:0]     load_len,
  output frame_kind_e       kind,
  output frame_kind_e       cur_kind,
  output logic              take,
  output logic              brk_lat,
  output logic              pre_pend,
  output logic              mark_pend
);
  // Character time in bits: start + data + optional ninth + stop.
  function automatic logic [LW-1:0] char_bits(input logic nine);
    return nine ? LW'(DATA_W + 3) : LW'(DATA_W + 2);
  endfunction

  // Data frame image, bit 0 goes out first; unused top bits stay 1.
  function automatic logic [FW-1:0] data_image(input logic [DATA_W-1:0] d,
                                               input logic b8,
                                               input logic nine);
    logic [FW-1:0] v;
    v           = '1;
    v[0]        = 1'b0;
    v[DATA_W:1] = d;
    if (nine) v[DATA_W+1] = b8;
    return v;
  endfunction

  logic en_q, brk_q;
  logic en_rise, brk_rise, pre_eff;

  assign en_rise  = tx_en && !en_q;
  assign brk_rise = brk_req && !brk_q;
  assign pre_eff  = pre_pend || en_rise;

  always_comb begin
    kind = FK_IDLE;
    if (slot && tx_en) begin
      if (brk_req || brk_lat)  kind = FK_BRK;
      else if (mark_pend)      kind = FK_MARK;
      else if (pre_eff)        kind = FK_PRE;
      else if (hold_full)      kind = FK_DATA;
    end
  end

  assign load = (kind != FK_IDLE);
  assign take = (kind == FK_DATA);

  always_comb begin
    load_vec = '1;
    load_len = char_bits(nine_bit);
    unique case (kind)
      FK_DATA: load_vec = data_image(hold_data, hold_b8, nine_bit);
      FK_BRK:  load_vec = '0;
      FK_MARK: load_len = LW'(1);
      default: load_vec = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      brk_q     <= 1'b0;
      brk_lat   <= 1'b0;
      pre_pend  <= 1'b0;
      mark_pend <= 1'b0;
      cur_kind  <= FK_IDLE;
    end else begin
      en_q  <= tx_en;
      brk_q <= brk_req;
      if (kind == FK_BRK)  brk_lat <= 1'b0;
      else if (brk_rise)   brk_lat <= 1'b1;
      pre_pend <= pre_eff && !(kind == FK_PRE || kind == FK_BRK);
      if (kind == FK_BRK)       mark_pend <= 1'b1;
      else if (kind == FK_MARK) mark_pend <= 1'b0;
      if (load)                         cur_kind <= kind;
      else if (bit_edge && frame_end)   cur_kind <= FK_IDLE;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int FW = 11,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_edge,
  input  logic          load,
  input  logic [FW-1:0] load_vec,
  input  logic [LW-1:0] load_len,
  output logic          txd,
  output logic          busy,
  output logic          frame_end
);
  logic [FW-1:0] sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
    end else if (bit_edge) begin
      if (load) begin
        sh   <= load_vec;
        left <= load_len;
      end else if (left != '0) begin
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  assign busy      = (left != '0);
  assign frame_end = bit_edge && (left == LW'(1));
  assign txd       = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_req,
  input  logic              nine_bit,
  input  logic              bit8_in,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int FW = DATA_W + 3;
  localparam int LW = $clog2(FW + 1);

  logic              bit_edge, busy, frame_end, slot;
  logic              load, take, brk_lat, pre_pend, mark_pend;
  logic              hold_full, hold_b8;
  logic [DATA_W-1:0] hold_data;
  logic [FW-1:0]     load_vec;
  logic [LW-1:0]     load_len;
  frame_kind_e       kind, cur_kind;
  logic              load_brk, cur_brk;

  sertx_bit_clock #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_clk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .bit_edge(bit_edge)
  );

  sertx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .accept(tx_en),
    .wr_data(wr_data), .bit8_in(bit8_in), .take(take),
    .full(hold_full), .data(hold_data), .b8(hold_b8)
  );

  assign slot = bit_edge && (!busy || frame_end);

  sertx_arbiter #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
    .nine_bit(nine_bit), .slot(slot), .bit_edge(bit_edge),
    .frame_end(frame_end), .hold_full(hold_full), .hold_data(hold_data),
    .hold_b8(hold_b8), .load(load), .load_vec(load_vec),
    .load_len(load_len), .kind(kind), .cur_kind(cur_kind), .take(take),
    .brk_lat(brk_lat), .pre_pend(pre_pend), .mark_pend(mark_pend)
  );

  sertx_shifter #(.FW(FW)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_edge(bit_edge), .load(load),
    .load_vec(load_vec), .load_len(load_len), .txd(txd), .busy(busy),
    .frame_end(frame_end)
  );

  assign load_brk  = (kind == FK_BRK);
  assign cur_brk   = (cur_kind == FK_BRK);
  assign buf_empty = !hold_full;
  assign tx_done   = !busy && !pre_pend && !brk_lat && !brk_req &&
                     !mark_pend && !hold_full;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic brk_req,
  input logic wr_stb,
  input logic txd,
  input logic buf_empty,
  input logic tx_done,
  input logic bit_edge,
  input logic load,
  input logic take,
  input logic frame_end,
  input logic cur_brk,
  input logic load_brk,
  input logic brk_lat,
  input logic pre_pend
);
  // R2: frames only begin on a bit boundary
  a_r2_load_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> bit_edge);

  // R4: empty flag only rises when the shifter takes the byte
  a_r4_empty_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(take));

  // R6: released break is followed by a high bit
  a_r6_mark_after: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cur_brk && !brk_req && !brk_lat) |=> txd);

  // R7: held break continues low with no gap
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cur_brk && brk_req && tx_en) |=> !txd);

  // R8: a starting break drops the pending preamble
  a_r8_pre_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    load_brk |=> !pre_pend);

  // R9: complete implies an idle high line
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd);

  // R10: writes while disabled leave the buffer empty
  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_en && buf_empty) |=> buf_empty);
endmodule

bind sertx_core sertx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
  .wr_stb(wr_stb), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
  .bit_edge(bit_edge), .load(load), .take(take), .frame_end(frame_end),
  .cur_brk(cur_brk), .load_brk(load_brk), .brk_lat(brk_lat),
  .pre_pend(pre_pend)
);

// File: tb/tb_sertx_core.sv
module tb_sertx_core;
  localparam int TPB = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tick_run = 1'b0;
  logic tx_en = 1'b0, brk_req = 1'b0, nine_bit = 1'b0, bit8_in = 1'b0;
  logic wr_stb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic txd, buf_empty, tx_done;

  int n_checks = 0, n_fail = 0;
  int ticks = 0, last_n = -1, cycles = 0;
  bit exp_q[$];
  string tag_q[$];
  event slot_ev;
  bit finished = 1'b0;

  sertx_core #(.TICKS_PER_BIT(TPB), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .brk_req(brk_req), .nine_bit(nine_bit), .bit8_in(bit8_in),
    .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd),
    .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always #2 clk = ~clk;

  always @(negedge clk) baud_tick <= tick_run ? ~baud_tick : 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) ticks <= 0;
    else if (baud_tick) ticks <= ticks + 1;
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one sample in the middle of every bit time.
  always @(negedge clk) begin
    if (!rst_n) begin
      last_n = -1;
    end else if (ticks % TPB == TPB / 2 && ticks != last_n) begin
      bit e;
      string t;
      last_n = ticks;
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = 1'b1;
        t = "R2 idle";
      end
      check(t, int'(txd), int'(e));
      -> slot_ev;
    end
  end

  task automatic push_const(bit v, int cnt, string tag);
    for (int i = 0; i < cnt; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_frame(logic [DW-1:0] d, bit nine, bit b8, string tag);
    exp_q.push_back(1'b0); tag_q.push_back(tag);
    for (int i = 0; i < DW; i++) begin
      exp_q.push_back(d[i]); tag_q.push_back(tag);
    end
    if (nine) begin
      exp_q.push_back(b8); tag_q.push_back(tag);
    end
    exp_q.push_back(1'b1); tag_q.push_back(tag);
  endtask

  task automatic write_byte(logic [DW-1:0] d, bit b8);
    wr_data = d; bit8_in = b8; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(slot_ev);
    @(slot_ev);
  endtask

  initial begin
    while (cycles < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 buf_empty", buf_empty, 1);
    check("R1 tx_done", tx_done, 1);
    tick_run = 1'b1;
    repeat (2) @(slot_ev);

    // Enable together with a write: preamble first, then the byte.
    @(slot_ev);
    push_const(1'b1, 10, "R5 preamble");
    push_frame(8'hA5, 1'b0, 1'b0, "R2 data A5");
    tx_en = 1'b1;
    write_byte(8'hA5, 1'b0);
    check("R4 empty after write", buf_empty, 0);
    check("R9 done low with preamble", tx_done, 0);
    drain();
    check("R9 done after drain", tx_done, 1);
    check("R4 empty after drain", buf_empty, 1);

    // Back-to-back bytes.
    @(slot_ev);
    push_frame(8'h3C, 1'b0, 1'b0, "R4 first 3C");
    push_frame(8'hC3, 1'b0, 1'b0, "R4 second C3");
    write_byte(8'h3C, 1'b0);
    @(slot_ev);
    check("R4 empty after move", buf_empty, 1);
    write_byte(8'hC3, 1'b0);
    check("R4 refilled", buf_empty, 0);
    drain();

    // Single break pulse.
    @(slot_ev);
    push_const(1'b0, 10, "R6 break");
    push_const(1'b1, 1, "R6 trailing one");
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    check("R9 done low with break", tx_done, 0);
    drain();
    check("R9 done after break", tx_done, 1);

    // Held break across three characters.
    @(slot_ev);
    push_const(1'b0, 30, "R7 held breaks");
    push_const(1'b1, 1, "R7 trailing one");
    brk_req = 1'b1;
    repeat (25) @(slot_ev);
    check("R9 done low while held", tx_done, 0);
    brk_req = 1'b0;
    drain();

    // 9-bit characters and 9-bit break.
    @(slot_ev);
    nine_bit = 1'b1;
    @(slot_ev);
    push_frame(8'h5A, 1'b1, 1'b1, "R3 nine b8=1");
    push_frame(8'h96, 1'b1, 1'b0, "R3 nine b8=0");
    write_byte(8'h5A, 1'b1);
    @(slot_ev);
    write_byte(8'h96, 1'b0);
    drain();
    @(slot_ev);
    push_const(1'b0, 11, "R3 long break");
    push_const(1'b1, 1, "R3 trailing one");
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    drain();
    @(slot_ev);
    nine_bit = 1'b0;

    // Break before the preamble begins replaces it.
    @(slot_ev);
    tx_en = 1'b0;
    repeat (2) @(slot_ev);
    push_const(1'b0, 10, "R8 break for preamble");
    push_const(1'b1, 1, "R8 trailing one");
    push_frame(8'h81, 1'b0, 1'b0, "R8 data right after");
    tx_en = 1'b1; brk_req = 1'b1;
    write_byte(8'h81, 1'b0);
    brk_req = 1'b0;
    drain();
    check("R8 done", tx_done, 1);

    // Disabled: writes ignored, then enable gives only a preamble.
    @(slot_ev);
    tx_en = 1'b0;
    @(slot_ev);
    write_byte(8'hFF, 1'b0);
    check("R10 write ignored", buf_empty, 1);
    repeat (3) @(slot_ev);
    check("R10 done stays", tx_done, 1);
    push_const(1'b1, 10, "R5 lone preamble");
    tx_en = 1'b1;
    @(negedge clk);
    check("R5 preamble pending", tx_done, 0);
    drain();
    check("R10 no stale byte", buf_empty, 1);
    check("R5 done after preamble", tx_done, 1);

    // Latched break is cleared by reset.
    @(slot_ev);
    tx_en = 1'b0;
    @(slot_ev);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    @(negedge clk);
    check("R11 break latched", tx_done, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 done after reset", tx_done, 1);
    check("R11 line high", txd, 1);
    @(slot_ev);
    push_const(1'b1, 10, "R11 preamble only");
    tx_en = 1'b1;
    drain();
    check("R11 done at end", tx_done, 1);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule